// File: doc/BRIEF.md
# Dual-Byte Stack Memory Unit

This block is a byte-wide last-in-first-out store with a wrapping 8-bit pointer, meant to be instantiated twice inside a small stack processor: once for the operand stack and once for the return stack. Each cycle it accepts at most one request. The request carries an operation code, a 16-bit data word and a depth index. Read results come back one clock later through a registered response port.

Single bytes and 16-bit words share one byte array. A word is kept as two consecutive bytes with the high byte deeper, so a word pushed in one operation can be taken apart byte by byte later, and the reverse also works. Drops move the pointer without producing a result. Peeks read at any depth below the pointer without moving it. All pointer arithmetic wraps modulo 256. No overflow or underflow condition is flagged; detecting those is left to the surrounding processor.

Top module: `dual_byte_stack`

## Requirements
- R1: A synchronous active-high reset sets the pointer `sp_out` to 0 and clears `rsp_valid` at the next clock edge.
- R2: Byte push (code 4'h1) writes `req_data[7:0]` at address `sp` and advances the pointer by one. It produces no response.
- R3: Byte pop (code 4'h3) retreats the pointer by one. One clock later it returns the byte at the new pointer in `rsp_data[7:0]`, with `rsp_data[15:8]` zero and `rsp_valid` high.
- R4: Word push (code 4'h2) writes `req_data[15:8]` at `sp` and `req_data[7:0]` at `sp+1`, and advances the pointer by two.
- R5: Word pop (code 4'h4) retreats the pointer by two. It returns `{byte at sp-2, byte at sp-1}`, which is the pushed word unchanged.
- R6: Drop byte (code 4'h5) and drop word (code 4'h6) retreat the pointer by one and two. They give no response and leave the stored bytes unchanged.
- R7: Byte peek (code 4'h7) with depth i returns the byte at `sp-i`, so depth 1 is the top byte. The pointer does not move.
- R8: Word peek (code 4'h8) with depth i returns `{byte at sp-i-1, byte at sp-i}`. Depth 1 gives the top word and depth 3 gives the word beneath it. The pointer does not move.
- R9: Every pointer and address computation wraps modulo 256 with no error indication, including a word that straddles addresses 255 and 0.
- R10: A request with `req_valid` low, or with code 4'h0 or 4'h9..4'hF, changes neither the pointer nor the stored bytes, and gives no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Operation code |
| req_data | input | 16 | Word to push; a byte push uses bits 7:0 |
| req_depth | input | 8 | Depth index for peeks |
| rsp_valid | output | 1 | Response present; high for one cycle after a pop or peek |
| rsp_data | output | 16 | Response word; a byte result is zero-extended |
| sp_out | output | 8 | Current stack pointer |

## Verification
A hand-computed vector table mixes byte and word operations on the same stored bytes. The same table pushes a word and reads it back as two bytes, so the tests can tell a high-byte-deeper layout from a swapped one. It also peeks at depth 3 after two byte pushes, which separates the top word from the word beneath it, and it follows a drop with a peek, which shows that a drop does not destroy data. The pointer is driven below zero, and a word is pushed across the 255/0 boundary, to expose any arithmetic that saturates or loses the carry. After that, all 256 bytes are filled and a long pseudo-random mix of pushes, pops and peeks runs against a queue model. This stage catches ordering faults that only show at particular pointer values. Requests held inactive and undefined codes are checked by peeking the location they could have overwritten.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [3:0] {
        OP_NOP    = 4'h0,
        OP_PUSH_B = 4'h1,
        OP_PUSH_W = 4'h2,
        OP_POP_B  = 4'h3,
        OP_POP_W  = 4'h4,
        OP_DROP_B = 4'h5,
        OP_DROP_W = 4'h6,
        OP_PEEK_B = 4'h7,
        OP_PEEK_W = 4'h8
    } stk_op_e;

    // Control word derived from one request.
    typedef struct packed {
        logic       wr_en;     // store at least one byte
        logic       wr_pair;   // store a second byte at sp+1
        logic       rd_en;     // produce a response
        logic       rd_pair;   // response is two bytes
        logic       rd_depth;  // read offset comes from the depth input
        logic [1:0] step_up;   // pointer increment
        logic [1:0] step_dn;   // pointer decrement
    } stk_ctl_t;

    function automatic stk_ctl_t decode_op(input logic valid, input logic [3:0] code);
        stk_ctl_t c;
        c = '0;
        if (valid) begin
            case (code)
                OP_PUSH_B: begin c.wr_en = 1'b1; c.step_up = 2'd1; end
                OP_PUSH_W: begin c.wr_en = 1'b1; c.wr_pair = 1'b1; c.step_up = 2'd2; end
                OP_POP_B:  begin c.rd_en = 1'b1; c.step_dn = 2'd1; end
                OP_POP_W:  begin c.rd_en = 1'b1; c.rd_pair = 1'b1; c.step_dn = 2'd2; end
                OP_DROP_B: begin c.step_dn = 2'd1; end
                OP_DROP_W: begin c.step_dn = 2'd2; end
                OP_PEEK_B: begin c.rd_en = 1'b1; c.rd_depth = 1'b1; end
                OP_PEEK_W: begin c.rd_en = 1'b1; c.rd_pair = 1'b1; c.rd_depth = 1'b1; end
                default:   c = '0;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/stk_ptr_unit.sv
module stk_ptr_unit
    import stk_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_ctl_t         ctl,
    input  logic [PTR_W-1:0] depth,
    output logic [PTR_W-1:0] sp,
    output logic [PTR_W-1:0] wr_addr_hi,
    output logic [PTR_W-1:0] wr_addr_lo,
    output logic [PTR_W-1:0] rd_addr_lo,
    output logic [PTR_W-1:0] rd_addr_hi
);
    logic [PTR_W-1:0] sp_q;
    logic [PTR_W-1:0] rd_offset;

    // All arithmetic below is PTR_W wide, so it wraps naturally.
    always_ff @(posedge clk) begin
        if (rst) sp_q <= '0;
        else     sp_q <= sp_q + PTR_W'(ctl.step_up) - PTR_W'(ctl.step_dn);
    end

    always_comb begin
        rd_offset  = ctl.rd_depth ? depth : PTR_W'(1);
        wr_addr_hi = sp_q;
        wr_addr_lo = sp_q + PTR_W'(1);
        rd_addr_lo = sp_q - rd_offset;
        rd_addr_hi = rd_addr_lo - PTR_W'(1);
    end

    assign sp = sp_q;
endmodule

// File: rtl/stk_byte_store.sv
module stk_byte_store #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 8,
    parameter int N_RD   = 2
) (
    input  logic                        clk,
    input  logic                        we_a,
    input  logic [PTR_W-1:0]            wa_a,
    input  logic [DATA_W-1:0]           wd_a,
    input  logic                        we_b,
    input  logic [PTR_W-1:0]            wa_b,
    input  logic [DATA_W-1:0]           wd_b,
    input  logic [N_RD-1:0][PTR_W-1:0]  ra,
    output logic [N_RD-1:0][DATA_W-1:0] rd
);
    localparam int DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Two write ports; the addresses of a pair always differ by one.
    always_ff @(posedge clk) begin
        if (we_a) cells[wa_a] <= wd_a;
        if (we_b) cells[wa_b] <= wd_b;
    end

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        assign rd[p] = cells[ra[p]];
    end
endmodule

// File: rtl/stk_rsp_reg.sv
module stk_rsp_reg #(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_en,
    input  logic                rd_pair,
    input  logic [DATA_W-1:0]   byte_hi,
    input  logic [DATA_W-1:0]   byte_lo,
    output logic                rsp_valid,
    output logic [2*DATA_W-1:0] rsp_data
);
    logic [2*DATA_W-1:0] word_d;

    always_comb begin
        word_d = rd_pair ? {byte_hi, byte_lo} : {{DATA_W{1'b0}}, byte_lo};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd_en;
            if (rd_en) rsp_data <= word_d;
        end
    end
endmodule

// File: rtl/dual_byte_stack.sv
module dual_byte_stack
    import stk_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [3:0]          req_op,
    input  logic [2*DATA_W-1:0] req_data,
    input  logic [PTR_W-1:0]    req_depth,
    output logic                rsp_valid,
    output logic [2*DATA_W-1:0] rsp_data,
    output logic [PTR_W-1:0]    sp_out
);
    localparam int N_RD = 2;

    stk_ctl_t                     ctl;
    logic [PTR_W-1:0]             wr_addr_hi, wr_addr_lo, rd_addr_lo, rd_addr_hi;
    logic [DATA_W-1:0]            wd_first, wd_second;
    logic [N_RD-1:0][PTR_W-1:0]   rd_addr;
    logic [N_RD-1:0][DATA_W-1:0]  rd_byte;

    always_comb begin
        ctl = decode_op(req_valid, req_op);
        // Byte push stores the low half; word push stores the high half first.
        wd_first   = ctl.wr_pair ? req_data[2*DATA_W-1:DATA_W] : req_data[DATA_W-1:0];
        wd_second  = req_data[DATA_W-1:0];
        rd_addr[0] = rd_addr_lo;
        rd_addr[1] = rd_addr_hi;
    end

    stk_ptr_unit #(.PTR_W(PTR_W)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .depth      (req_depth),
        .sp         (sp_out),
        .wr_addr_hi (wr_addr_hi),
        .wr_addr_lo (wr_addr_lo),
        .rd_addr_lo (rd_addr_lo),
        .rd_addr_hi (rd_addr_hi)
    );

    stk_byte_store #(.DATA_W(DATA_W), .PTR_W(PTR_W), .N_RD(N_RD)) u_store (
        .clk  (clk),
        .we_a (ctl.wr_en & ~rst),
        .wa_a (wr_addr_hi),
        .wd_a (wd_first),
        .we_b (ctl.wr_pair & ~rst),
        .wa_b (wr_addr_lo),
        .wd_b (wd_second),
        .ra   (rd_addr),
        .rd   (rd_byte)
    );

    stk_rsp_reg #(.DATA_W(DATA_W)) u_rsp (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (ctl.rd_en),
        .rd_pair   (ctl.rd_pair),
        .byte_hi   (rd_byte[1]),
        .byte_lo   (rd_byte[0]),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );
endmodule

// File: rtl/stk_checker.sv
module stk_checker
    import stk_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [3:0]          req_op,
    input logic [2*DATA_W-1:0] req_data,
    input logic [PTR_W-1:0]    req_depth,
    input logic                rsp_valid,
    input logic [2*DATA_W-1:0] rsp_data,
    input logic [PTR_W-1:0]    sp_out
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (sp_out == '0) && !rsp_valid);

    assert_push_byte_step_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_PUSH_B) |=> sp_out == PTR_W'($past(sp_out) + 1) && !rsp_valid);

    assert_pop_byte_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_POP_B) |=>
            sp_out == PTR_W'($past(sp_out) - 1) && rsp_valid && rsp_data[2*DATA_W-1:DATA_W] == '0);

    assert_push_word_step_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_PUSH_W) |=> sp_out == PTR_W'($past(sp_out) + 2));

    assert_word_roundtrip_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_PUSH_W) ##1 (req_valid && req_op == OP_POP_W) |=>
            rsp_valid && rsp_data == $past(req_data, 2) && sp_out == $past(sp_out, 2));

    assert_drop_byte_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_DROP_B) |=> sp_out == PTR_W'($past(sp_out) - 1) && !rsp_valid);

    assert_drop_word_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_DROP_W) |=> sp_out == PTR_W'($past(sp_out) - 2) && !rsp_valid);

    assert_peek_top_byte_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_PUSH_B) ##1 (req_valid && req_op == OP_PEEK_B && req_depth == PTR_W'(1)) |=>
            rsp_valid && rsp_data[DATA_W-1:0] == $past(req_data[DATA_W-1:0], 2)
            && rsp_data[2*DATA_W-1:DATA_W] == '0);

    assert_peek_keeps_sp_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_op == OP_PEEK_B || req_op == OP_PEEK_W)) |=> $stable(sp_out) && rsp_valid);

    assert_idle_no_effect_R10: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || req_op == OP_NOP || req_op > OP_PEEK_W) |=> $stable(sp_out) && !rsp_valid);
endmodule

bind dual_byte_stack stk_checker #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_stk_checker (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_data  (req_data),
    .req_depth (req_depth),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .sp_out    (sp_out)
);

// File: tb/test_dual_byte_stack.sv
module test_dual_byte_stack;
    import stk_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_op = 4'h0;
    logic [15:0] req_data = 16'h0;
    logic [7:0]  req_depth = 8'h0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic [7:0]  sp_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    dual_byte_stack i_dual_byte_stack (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_data  (req_data),
        .req_depth (req_depth),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .sp_out    (sp_out)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [15:0] din;
        logic [7:0]  dep;
        logic        ev;
        logic [15:0] ed;
        logic [7:0]  esp;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VT [NV] = '{
        '{4'h1, 16'h00A5, 8'd0, 1'b0, 16'h0000, 8'h01},  // R2 byte push
        '{4'h2, 16'h1234, 8'd0, 1'b0, 16'h0000, 8'h03},  // R4 word push
        '{4'h7, 16'h0000, 8'd1, 1'b1, 16'h0034, 8'h03},  // R7 top byte = low half
        '{4'h7, 16'h0000, 8'd2, 1'b1, 16'h0012, 8'h03},  // R4 high byte deeper
        '{4'h8, 16'h0000, 8'd1, 1'b1, 16'h1234, 8'h03},  // R8 top word
        '{4'h1, 16'h0077, 8'd0, 1'b0, 16'h0000, 8'h04},  // R2
        '{4'h1, 16'h0088, 8'd0, 1'b0, 16'h0000, 8'h05},  // R2
        '{4'h8, 16'h0000, 8'd3, 1'b1, 16'h1234, 8'h05},  // R8 next-to-top word
        '{4'h4, 16'h0000, 8'd0, 1'b1, 16'h7788, 8'h03},  // R5 word pop of two byte pushes
        '{4'h5, 16'h0000, 8'd0, 1'b0, 16'h0000, 8'h02},  // R6 drop byte
        '{4'h7, 16'h0000, 8'd1, 1'b1, 16'h0012, 8'h02},  // R6 data below survives
        '{4'h0, 16'hFFFF, 8'd0, 1'b0, 16'h0000, 8'h02},  // R10 nop code
        '{4'hF, 16'hFFFF, 8'd0, 1'b0, 16'h0000, 8'h02},  // R10 undefined code
        '{4'h3, 16'h0000, 8'd0, 1'b1, 16'h0012, 8'h01},  // R3 byte pop
        '{4'h3, 16'h0000, 8'd0, 1'b1, 16'h00A5, 8'h00},  // R3 byte pop to empty
        '{4'h6, 16'h0000, 8'd0, 1'b0, 16'h0000, 8'hFE},  // R9 drop word below zero
        '{4'h2, 16'hBEEF, 8'd0, 1'b0, 16'h0000, 8'h00},  // R9 push wraps to 0
        '{4'h8, 16'h0000, 8'd1, 1'b1, 16'hBEEF, 8'h00},  // R9 peek across 0
        '{4'h2, 16'hCAFE, 8'd0, 1'b0, 16'h0000, 8'h02},  // R4
        '{4'h4, 16'h0000, 8'd0, 1'b1, 16'hCAFE, 8'h00},  // R5
        '{4'h4, 16'h0000, 8'd0, 1'b1, 16'hBEEF, 8'hFE}   // R9 pop straddling 255/0
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Entered at a falling edge; returns at the next falling edge with outputs updated.
    task automatic apply(input logic v, input logic [3:0] op, input logic [15:0] d, input logic [7:0] dep);
        req_valid = v;
        req_op    = op;
        req_data  = d;
        req_depth = dep;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    logic [7:0] ref_mem [256];
    logic [7:0] ref_sp;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 sp", {24'h0, sp_out}, 32'h0);
        chk("R1 valid", {31'h0, rsp_valid}, 32'h0);

        for (int k = 0; k < NV; k++) begin
            apply(1'b1, VT[k].op, VT[k].din, VT[k].dep);
            chk($sformatf("vec%0d sp", k), {24'h0, sp_out}, {24'h0, VT[k].esp});
            chk($sformatf("vec%0d valid", k), {31'h0, rsp_valid}, {31'h0, VT[k].ev});
            if (VT[k].ev) chk($sformatf("vec%0d data", k), {16'h0, rsp_data}, {16'h0, VT[k].ed});
        end

        // R10 inactive request: sp holds and the byte at sp (0xBE) is not overwritten
        apply(1'b0, OP_PUSH_B, 16'h0055, 8'd0);
        chk("R10 sp", {24'h0, sp_out}, 32'hFE);
        chk("R10 valid", {31'h0, rsp_valid}, 32'h0);
        apply(1'b1, OP_PEEK_B, 16'h0, 8'd0);
        chk("R10 content", {16'h0, rsp_data}, 32'h00BE);

        // Fill all 256 bytes with word pushes (R4, R9), mirrored in a queue model
        ref_sp = 8'hFE;
        for (int k = 0; k < 128; k++) begin
            logic [15:0] w;
            w = {8'(k * 3 + 1), 8'(k * 7 + 5)};
            apply(1'b1, OP_PUSH_W, w, 8'd0);
            ref_mem[ref_sp] = w[15:8];
            ref_mem[8'(ref_sp + 1)] = w[7:0];
            ref_sp = 8'(ref_sp + 2);
        end
        chk("R9 fill wrap sp", {24'h0, sp_out}, {24'h0, ref_sp});

        // Mixed pseudo-random sequence against the model (R2 R3 R4 R5 R7 R8 R9)
        lfsr = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            logic [2:0]  sel;
            logic [7:0]  dep;
            logic [15:0] exp_w;
            logic        rd;
            lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sel   = 3'(lfsr[2:0] % 6);
            dep   = {6'h0, lfsr[5:4]} + 8'd1;
            rd    = 1'b1;
            exp_w = 16'h0;
            case (sel)
                3'd0: begin
                    apply(1'b1, OP_PUSH_B, lfsr, 8'd0);
                    ref_mem[ref_sp] = lfsr[7:0]; ref_sp = 8'(ref_sp + 1); rd = 1'b0;
                end
                3'd1: begin
                    apply(1'b1, OP_PUSH_W, lfsr, 8'd0);
                    ref_mem[ref_sp] = lfsr[15:8]; ref_mem[8'(ref_sp + 1)] = lfsr[7:0];
                    ref_sp = 8'(ref_sp + 2); rd = 1'b0;
                end
                3'd2: begin
                    apply(1'b1, OP_POP_B, 16'h0, 8'd0);
                    ref_sp = 8'(ref_sp - 1); exp_w = {8'h0, ref_mem[ref_sp]};
                end
                3'd3: begin
                    apply(1'b1, OP_POP_W, 16'h0, 8'd0);
                    exp_w = {ref_mem[8'(ref_sp - 2)], ref_mem[8'(ref_sp - 1)]};
                    ref_sp = 8'(ref_sp - 2);
                end
                3'd4: begin
                    apply(1'b1, OP_PEEK_B, 16'h0, dep);
                    exp_w = {8'h0, ref_mem[8'(ref_sp - dep)]};
                end
                default: begin
                    apply(1'b1, OP_PEEK_W, 16'h0, dep);
                    exp_w = {ref_mem[8'(ref_sp - dep - 1)], ref_mem[8'(ref_sp - dep)]};
                end
            endcase
            chk("R9 mixed sp", {24'h0, sp_out}, {24'h0, ref_sp});
            chk("R7 R8 mixed valid", {31'h0, rsp_valid}, {31'h0, rd});
            if (rd) chk("R3 R5 R7 R8 mixed data", {16'h0, rsp_data}, {16'h0, exp_w});
        end

        // R1 reset in mid-run
        apply(1'b1, OP_PUSH_W, 16'h4242, 8'd0);
        rst = 1'b1;
        req_valid = 1'b1;
        req_op = OP_PEEK_B;
        @(negedge clk);
        rst = 1'b0;
        req_valid = 1'b0;
        chk("R1 mid sp", {24'h0, sp_out}, 32'h0);
        chk("R1 mid valid", {31'h0, rsp_valid}, 32'h0);

        done = 1'b1;
        summary();
    end
endmodule